// File: doc/BRIEF.md
# Soft-Switching Frequency Regulator

This block sets the switching period of a half-bridge PWM generator so that the power stage runs right at the edge of lossless soft switching. An internal counter produces two complementary gate commands: a high-side gate and a low-side gate, separated by a programmable dead time. The length of each switching cycle is a tune code multiplied by a fixed number of clock ticks. A larger code gives a longer period and so a lower switching frequency.

Two one-bit inputs report whether the switch node has already reached the rail its next transition heads for. The upper-rail flag belongs to the low-to-high transition and the lower-rail flag to the high-to-low transition. Each flag is captured only at the clock edge where its gate turns on. At the end of every cycle the tune code moves by exactly one step. If both transitions were complete in time, the code goes down and the frequency rises. If either transition was late, the code goes up and the frequency falls.

The code is clamped to a window. The upper clamp acts as a floor on frequency, and under heavy load the stage then settles there and runs hard switching. Near the soft-switching boundary the decisions alternate from cycle to cycle. The current code and a per-cycle up/down strobe are brought out for observation.

Top module: `zvs_freq_tuner`

## Requirements
- R1: The upper-rail flag is captured only at the clock edge where the high-side gate turns on, and the lower-rail flag only where the low-side gate turns on. Values the flags take at any other time have no effect on the decision.
- R2: If both captured flags of a cycle are 1, the code decreases by one at the end of that cycle, and `step_up` (frequency increase) is high for one clock together with the new code.
- R3: If either captured flag of a cycle is 0, the code increases by one at the end of that cycle, and `step_dn` is high for one clock together with the new code.
- R4: Exactly one decision is taken per switching cycle, always at its last tick and always of size one. A cycle lasts `tune_code * TICKS_PER_CODE` clocks, measured between consecutive strobes, using the code in force during that cycle.
- R5: The code stays within `CODE_MIN`..`CODE_MAX` (default 36..90). A decision that would leave the window still raises its strobe, but the code is held at the limit.
- R6: The two gates are never high together. Each gate turn-on is preceded by exactly `DEAD_TICKS` clocks with both gates low. The high-side gate is on from tick `DEAD_TICKS` to the mid-cycle tick, and the low-side gate is on from the mid-cycle tick plus `DEAD_TICKS` until the cycle ends.
- R7: During and after synchronous reset the code is `CODE_MAX`, both gates and both strobes are low, and the first switching cycle after reset produces no decision. The first strobe therefore appears `2 * CODE_MAX * TICKS_PER_CODE` clocks after reset is released.
- R8: When the rail flags are 1 at and above some code value and 0 below it, the controller settles there and `step_up` and `step_dn` alternate on successive cycles, with the code moving between two neighbouring values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rail_hi_ok | input | 1 | Switch node has reached the upper rail (low-to-high transition done) |
| rail_lo_ok | input | 1 | Switch node has reached the lower rail (high-to-low transition done) |
| gate_hs | output | 1 | High-side gate command |
| gate_ls | output | 1 | Low-side gate command |
| tune_code | output | $clog2(CODE_MAX+1) | Current tune code; period is this times TICKS_PER_CODE |
| step_up | output | 1 | One-clock strobe: code lowered, frequency raised |
| step_dn | output | 1 | One-clock strobe: code raised, frequency lowered |

## Verification
The bench keeps the default code window of 36 to 90 and the default dead time of 5 clocks, but builds the block with `TICKS_PER_CODE` set to 2. This shortens a switching cycle to between 72 and 180 clocks. The whole descent from the upper clamp to the lower clamp then fits in a few thousand clocks, and so does a closed-loop run in which the rail flags follow a code threshold, which makes both clamps and the cycle-by-cycle alternation reachable. The short cycles also allow the flags to be flipped just after a gate turns on, to show that only the captured value counts.

// File: rtl/zvs_tune_pkg.sv
// Package: shared types for the soft-switching frequency regulator.
// Assumes: nothing beyond IEEE 1800-2017.
package zvs_tune_pkg;

    // Outcome of one end-of-cycle evaluation.
    typedef enum logic [1:0] {
        DEC_HOLD   = 2'd0,
        DEC_FASTER = 2'd1,
        DEC_SLOWER = 2'd2
    } dec_e;

    // One captured rail flag together with its capture-valid bit.
    typedef struct packed {
        logic seen;
        logic ok;
    } rail_smp_t;

endpackage

// File: rtl/zvs_pwm_core.sv
// Module: zvs_pwm_core
// Counter-based half-bridge PWM generator with a fixed 50 % duty cycle
// and complementary gates separated by dead time. The period is
// code * TICKS_PER_CODE clocks. The module flags the clock edge at which
// each gate turns on and the last tick of each cycle.
// Assumes: half period > DEAD_TICKS and half + DEAD_TICKS < period - 1,
// and the code changes only on the edge that ends a cycle.
module zvs_pwm_core #(
    parameter int CODE_W         = 7,
    parameter int CNT_W          = 11,
    parameter int TICKS_PER_CODE = 20,
    parameter int DEAD_TICKS     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              gate_hs,
    output logic              gate_ls,
    output logic              hs_on_evt,
    output logic              ls_on_evt,
    output logic              cycle_end
);

    localparam int IDLE_W = $clog2(DEAD_TICKS + 2) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] dead;
    logic             hs_d;
    logic             ls_d;
    logic [IDLE_W-1:0] idle_cnt;

    // Derive period, midpoint, gate windows and turn-on events from the count.
    always_comb begin
        period    = CNT_W'(code) * CNT_W'(TICKS_PER_CODE);
        half      = period >> 1;
        dead      = CNT_W'(DEAD_TICKS);
        cycle_end = (cnt == (period - CNT_W'(1)));
        hs_d      = (cnt >= dead) && (cnt < half);
        ls_d      = (cnt >= (half + dead));
        hs_on_evt = hs_d && !gate_hs;
        ls_on_evt = ls_d && !gate_ls;
    end

    // Tick counter that wraps at the end of each switching cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cycle_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Registered gate commands, so the outputs are free of glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_hs <= 1'b0;
            gate_ls <= 1'b0;
        end else begin
            gate_hs <= hs_d;
            gate_ls <= ls_d;
        end
    end

    // Count of consecutive clocks with both gates low (assertion support).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (!gate_hs && !gate_ls) begin
            if (idle_cnt <= IDLE_W'(DEAD_TICKS)) begin
                idle_cnt <= idle_cnt + IDLE_W'(1);
            end
        end else begin
            idle_cnt <= '0;
        end
    end

    AST_GATES_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(gate_hs && gate_ls)); // R6
    AST_DEAD_HS: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_hs) |-> (idle_cnt >= IDLE_W'(DEAD_TICKS))); // R6
    AST_DEAD_LS: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_ls) |-> (idle_cnt >= IDLE_W'(DEAD_TICKS))); // R6

endmodule

// File: rtl/zvs_rail_sampler.sv
// Module: zvs_rail_sampler
// Captures each rail-reached flag on the edge where its gate turns on,
// and holds it with a valid bit until the cycle ends.
// Assumes: the turn-on events never coincide with the cycle-end tick.
module zvs_rail_sampler
    import zvs_tune_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hs_on_evt,
    input  logic      ls_on_evt,
    input  logic      cycle_end,
    input  logic      rail_hi_ok,
    input  logic      rail_lo_ok,
    output rail_smp_t hi_smp,
    output rail_smp_t lo_smp
);

    // Upper-rail capture at high-side turn-on; valid cleared at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_smp <= '0;
        end else if (hs_on_evt) begin
            hi_smp.seen <= 1'b1;
            hi_smp.ok   <= rail_hi_ok;
        end else if (cycle_end) begin
            hi_smp.seen <= 1'b0;
        end
    end

    // Lower-rail capture at low-side turn-on; valid cleared at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_smp <= '0;
        end else if (ls_on_evt) begin
            lo_smp.seen <= 1'b1;
            lo_smp.ok   <= rail_lo_ok;
        end else if (cycle_end) begin
            lo_smp.seen <= 1'b0;
        end
    end

    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !hs_on_evt |=> $stable(hi_smp.ok)); // R1
    AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ls_on_evt |=> $stable(lo_smp.ok)); // R1

endmodule

// File: rtl/zvs_tune_ctrl.sv
// Module: zvs_tune_ctrl
// Bang-bang tune register. At each cycle end it lowers the code by one
// when both captured flags are good and raises it by one otherwise,
// clamped to [CODE_MIN, CODE_MAX]. The first cycle after reset only
// primes the controller. A transition with no capture counts as late.
// Assumes: cycle_end is high for one clock per switching cycle.
module zvs_tune_ctrl
    import zvs_tune_pkg::*;
#(
    parameter int CODE_W   = 7,
    parameter int CODE_MIN = 36,
    parameter int CODE_MAX = 90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cycle_end,
    input  rail_smp_t         hi_smp,
    input  rail_smp_t         lo_smp,
    output logic [CODE_W-1:0] code,
    output logic              step_up,
    output logic              step_dn
);

    logic primed;
    dec_e decision;
    logic [CODE_W-1:0] code_faster;
    logic [CODE_W-1:0] code_slower;

    // Pick the decision and the clamped neighbour codes.
    always_comb begin
        if (!cycle_end || !primed) begin
            decision = DEC_HOLD;
        end else if (hi_smp.seen && hi_smp.ok && lo_smp.seen && lo_smp.ok) begin
            decision = DEC_FASTER;
        end else begin
            decision = DEC_SLOWER;
        end
        code_faster = (code > CODE_W'(CODE_MIN)) ? code - CODE_W'(1) : code;
        code_slower = (code < CODE_W'(CODE_MAX)) ? code + CODE_W'(1) : code;
    end

    // Tune register, priming flag and one-clock decision strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code    <= CODE_W'(CODE_MAX);
            primed  <= 1'b0;
            step_up <= 1'b0;
            step_dn <= 1'b0;
        end else begin
            step_up <= (decision == DEC_FASTER);
            step_dn <= (decision == DEC_SLOWER);
            if (cycle_end) begin
                primed <= 1'b1;
            end
            case (decision)
                DEC_FASTER: code <= code_faster;
                DEC_SLOWER: code <= code_slower;
                default:    code <= code;
            endcase
        end
    end

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (code >= CODE_W'(CODE_MIN)) && (code <= CODE_W'(CODE_MAX))); // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(step_up && step_dn)); // R2
    AST_STROBE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) (step_up || step_dn) |-> $past(cycle_end)); // R4
    AST_CODE_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n) (code != $past(code)) |-> (step_up || step_dn)); // R4
    AST_UP_LOWERS: assert property (@(posedge clk) disable iff (!rst_n) step_up |-> ((code == $past(code) - CODE_W'(1)) || (code == CODE_W'(CODE_MIN)))); // R2
    AST_DN_RAISES: assert property (@(posedge clk) disable iff (!rst_n) step_dn |-> ((code == $past(code) + CODE_W'(1)) || (code == CODE_W'(CODE_MAX)))); // R3

endmodule

// File: rtl/zvs_freq_tuner.sv
// Module: zvs_freq_tuner (top)
// Soft-switching frequency regulator: the PWM core, the rail-flag sampler
// and the tune controller, connected in a once-per-cycle loop.
// Assumes: rail flags are synchronous to clk; TICKS_PER_CODE and
// DEAD_TICKS leave each half period longer than the dead time.
module zvs_freq_tuner #(
    parameter int CODE_MIN       = 36,
    parameter int CODE_MAX       = 90,
    parameter int TICKS_PER_CODE = 20,
    parameter int DEAD_TICKS     = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rail_hi_ok,
    input  logic                          rail_lo_ok,
    output logic                          gate_hs,
    output logic                          gate_ls,
    output logic [$clog2(CODE_MAX+1)-1:0] tune_code,
    output logic                          step_up,
    output logic                          step_dn
);

    import zvs_tune_pkg::*;

    localparam int CODE_W = $clog2(CODE_MAX + 1);
    localparam int CNT_W  = $clog2(CODE_MAX * TICKS_PER_CODE + 1);

    logic      hs_on_evt;
    logic      ls_on_evt;
    logic      cycle_end;
    rail_smp_t hi_smp;
    rail_smp_t lo_smp;

    zvs_pwm_core #(
        .CODE_W         (CODE_W),
        .CNT_W          (CNT_W),
        .TICKS_PER_CODE (TICKS_PER_CODE),
        .DEAD_TICKS     (DEAD_TICKS)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .code      (tune_code),
        .gate_hs   (gate_hs),
        .gate_ls   (gate_ls),
        .hs_on_evt (hs_on_evt),
        .ls_on_evt (ls_on_evt),
        .cycle_end (cycle_end)
    );

    zvs_rail_sampler u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_on_evt  (hs_on_evt),
        .ls_on_evt  (ls_on_evt),
        .cycle_end  (cycle_end),
        .rail_hi_ok (rail_hi_ok),
        .rail_lo_ok (rail_lo_ok),
        .hi_smp     (hi_smp),
        .lo_smp     (lo_smp)
    );

    zvs_tune_ctrl #(
        .CODE_W   (CODE_W),
        .CODE_MIN (CODE_MIN),
        .CODE_MAX (CODE_MAX)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cycle_end (cycle_end),
        .hi_smp    (hi_smp),
        .lo_smp    (lo_smp),
        .code      (tune_code),
        .step_up   (step_up),
        .step_dn   (step_dn)
    );

endmodule

// File: tb/zvs_freq_tuner_tb.sv
// Scoreboard bench: run_cycle pushes the expected decision, code and
// cycle length; a monitor pops and compares them at each strobe.
module zvs_freq_tuner_tb;

    localparam int CMIN  = 36;
    localparam int CMAX  = 90;
    localparam int TPC   = 2;
    localparam int DEAD  = 5;
    localparam int BOUND = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rail_hi_ok = 1'b0;
    logic rail_lo_ok = 1'b0;
    logic gate_hs;
    logic gate_ls;
    logic [6:0] tune_code;
    logic step_up;
    logic step_dn;

    always #10 clk = ~clk;

    zvs_freq_tuner #(
        .CODE_MIN       (CMIN),
        .CODE_MAX       (CMAX),
        .TICKS_PER_CODE (TPC),
        .DEAD_TICKS     (DEAD)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rail_hi_ok (rail_hi_ok),
        .rail_lo_ok (rail_lo_ok),
        .gate_hs    (gate_hs),
        .gate_ls    (gate_ls),
        .tune_code  (tune_code),
        .step_up    (step_up),
        .step_dn    (step_dn)
    );

    typedef struct {
        bit    up;
        int    code;
        int    period;
        string req;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0;
    int n_fail = 0;
    int model_code = CMAX;
    bit first = 1'b1;
    int edges = 0;
    int last_edge = 0;
    bit gap_on = 1'b0;
    int off_run = 0;
    bit prev_hs = 1'b0;
    bit prev_ls = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Driver: push the expected result of one cycle, drive the flags, wait for the strobe.
    // mode 1: upper flag 1 at capture, dropped after; mode 2: 0 at capture, raised after.
    task automatic run_cycle(input bit hi, input bit lo, input int mode, input string req);
        exp_t e;
        e.up = hi && lo;
        e.period = first ? 2 * model_code * TPC : model_code * TPC;
        if (e.up) model_code = (model_code > CMIN) ? model_code - 1 : model_code;
        else      model_code = (model_code < CMAX) ? model_code + 1 : model_code;
        e.code = model_code;
        e.req = req;
        sb.push_back(e);
        rail_hi_ok = hi;
        rail_lo_ok = lo;
        if (first) begin
            rst_n = 1'b1;
            first = 1'b0;
        end
        if (mode != 0) begin
            @(posedge gate_hs);
            #1 rail_hi_ok = ~rail_hi_ok;
        end
        do @(negedge clk); while (!(step_up || step_dn));
    endtask

    always @(posedge clk) if (rst_n) edges++;

    // Monitor: compare each strobe against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && (step_up || step_dn)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R4", "strobe with no expected item", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(step_up == e.up, e.req, "step_up direction", step_up, e.up);
                chk(step_dn == !e.up, e.req, "step_dn direction", step_dn, !e.up);
                chk(tune_code == e.code, e.req, "code after decision", tune_code, e.code);
                chk((edges - last_edge) == e.period, "R4", "cycle length in clocks", edges - last_edge, e.period);
            end
            last_edge = edges;
        end
    end

    // Gate monitor: no overlap, exact dead gap before every turn-on (R6).
    always @(negedge clk) begin
        if (!rst_n) begin
            off_run = 0;
            prev_hs = 1'b0;
            prev_ls = 1'b0;
        end else begin
            chk(!(gate_hs && gate_ls), "R6", "both gates high", 1, 0);
            if (gate_hs && !prev_hs && gap_on) chk(off_run == DEAD, "R6", "dead gap before high-side", off_run, DEAD);
            if (gate_ls && !prev_ls && gap_on) chk(off_run == DEAD, "R6", "dead gap before low-side", off_run, DEAD);
            if (!gate_hs && !gate_ls) off_run++;
            else off_run = 0;
            prev_hs = gate_hs;
            prev_ls = gate_ls;
            if (step_up || step_dn) gap_on = 1'b1;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(1'b0, "R4", "watchdog expired", 200000, 0);
        summary();
        $finish;
    end

    initial begin : stim
        bit prev_up;
        repeat (4) @(negedge clk);
        chk(!gate_hs && !gate_ls, "R7", "gates during reset", {gate_hs, gate_ls}, 0);
        chk(tune_code == CMAX, "R7", "code during reset", tune_code, CMAX);
        chk(!step_up && !step_dn, "R7", "strobes during reset", {step_up, step_dn}, 0);

        // R7 first decision after two cycles; R5 late at the upper clamp holds 90
        run_cycle(0, 0, 0, "R5");
        run_cycle(0, 0, 0, "R5");
        // R2 both in time
        run_cycle(1, 1, 0, "R2");
        run_cycle(1, 1, 0, "R2");
        run_cycle(1, 1, 0, "R2");
        // R3 either late
        run_cycle(1, 0, 0, "R3");
        run_cycle(0, 1, 0, "R3");
        run_cycle(0, 0, 0, "R3");
        // R1 only the captured value counts
        run_cycle(1, 1, 1, "R1");
        run_cycle(0, 1, 2, "R1");
        // R2 descend to the lower clamp, then R5 hold there
        while (model_code > CMIN) run_cycle(1, 1, 0, "R2");
        run_cycle(1, 1, 0, "R5");
        run_cycle(1, 1, 0, "R5");
        // R8 closed loop with a boundary at BOUND
        for (int i = 0; i < 25; i++) begin
            bit ok;
            ok = (model_code >= BOUND);
            run_cycle(ok, ok, 0, "R8");
        end
        prev_up = step_up;
        for (int i = 0; i < 10; i++) begin
            bit ok;
            ok = (model_code >= BOUND);
            run_cycle(ok, ok, 0, "R8");
            chk(step_up != prev_up, "R8", "decisions alternate", step_up, !prev_up);
            chk(tune_code == BOUND || tune_code == BOUND - 1, "R8", "code at boundary", tune_code, BOUND);
            prev_up = step_up;
        end
        repeat (10) @(negedge clk);
        chk(sb.size() == 0, "R4", "expected items left over", sb.size(), 0);
        summary();
        $finish;
    end

endmodule